// File: doc/BRIEF.md
# Three-Bus Shared Memory Module with Fixed Access Latency

This block is one module of a shared word store that several processor elements reach over three separate system buses. Each bus owns one port. In any clock all three ports may read, and they may read the same word or three different words. Every accepted access finishes exactly four clocks after it was presented. A compiler can therefore plan bus traffic at clock level and pass a word from one processor to another in eight clocks: one write, then one read.

Writes are serialised. When several ports write in the same clock, the lowest-numbered port is taken. The other writers get no completion and must present their request again in a later clock. A read that meets a write to the same word in the same clock returns the word as it was before that write. Any access from the next clock on sees the new value. The system address carries a module number in its upper bits, and this instance answers only to its own number.

Top module: `csm_multiport`

## Requirements
- R1: While reset is held, and until an accepted request has passed through the pipeline, every `bus_done` bit is 0.
- R2: A selected read presented on port p in clock c raises `bus_done[p]` for exactly one clock, in clock c+4. In that clock `bus_rdata[p]` carries the stored word.
- R3: The three ports can read in the same clock, whether they name the same word or different words. None of them is stalled, and each completes in clock c+4 with its own data.
- R4: A write that is accepted in clock c stores `bus_wdata[p]` at its word and raises `bus_done[p]` in clock c+4. Later reads return the stored word.
- R5: When several selected writes arrive in the same clock, only the lowest-numbered port is accepted. Each other writer stores nothing and gets no done pulse four clocks later. A retry in a later clock is handled like a fresh request.
- R6: A read and a write to the same word in the same clock return the old word to the reader. A read in any later clock returns the new word.
- R7: A request is selected only when address bits [SYS_AW-1:WORD_AW] equal MODULE_ID. Bits [WORD_AW-1:0] give the word index. An unselected read or write writes nothing and produces no done pulse.
- R8: `bus_rdata[p]` is all zero in every clock where `bus_done[p]` is 0, and also in a clock where the completing access is a write.
- R9: Each port accepts a new request in every clock. Back-to-back mixed traffic completes in request order, and each access completes exactly four clocks after it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | NPORT | Request present, one bit per bus |
| bus_we | input | NPORT | 1 = write, 0 = read, one bit per bus |
| bus_addr | input | NPORT x SYS_AW | System address per bus: module number above, word index below |
| bus_wdata | input | NPORT x DATA_W | Write word per bus |
| bus_rdata | output | NPORT x DATA_W | Read word per bus, valid with done |
| bus_done | output | NPORT | One-clock completion pulse per bus |

## Verification
The embedded properties check several rules on every clock. Each selected read completes exactly four clocks later. No done pulse appears without a request four clocks earlier. A losing writer and an unselected request never complete. Read data stays zero when no read is completing. What these properties cannot show is whether the right word came back. The bench covers this with its scenarios: old-versus-new data when a read and a write to one word meet in the same clock, the content after a lost write and its retry, three-way reads of one word, and long random mixed traffic compared against a behavioural model of the store.

// File: rtl/csm_multiport.sv
module csm_multiport #(
  parameter int DATA_W    = 32,
  parameter int WORD_AW   = 8,
  parameter int SYS_AW    = 10,
  parameter int MODULE_ID = 1,
  parameter int NPORT     = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPORT-1:0]               bus_valid,
  input  logic [NPORT-1:0]               bus_we,
  input  logic [NPORT-1:0][SYS_AW-1:0]   bus_addr,
  input  logic [NPORT-1:0][DATA_W-1:0]   bus_wdata,
  output logic [NPORT-1:0][DATA_W-1:0]   bus_rdata,
  output logic [NPORT-1:0]               bus_done
);
  localparam int LAT   = 4;
  localparam int DEPTH = 1 << WORD_AW;
  localparam int SEL_W = SYS_AW - WORD_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [NPORT-1:0] sel, rd_hit, wr_req, grant, accept;
  logic               wr_en;
  logic [WORD_AW-1:0] wr_idx;
  logic [DATA_W-1:0]  wr_data;

  for (genvar p = 0; p < NPORT; p++) begin : g_sel
    assign sel[p] = bus_valid[p] && (bus_addr[p][SYS_AW-1:WORD_AW] == SEL_W'(MODULE_ID));
  end

  assign rd_hit = sel & ~bus_we;
  assign wr_req = sel & bus_we;
  assign grant  = wr_req & (~wr_req + 1'b1);
  assign accept = rd_hit | grant;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = '0;
    wr_data = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (grant[p]) begin
        wr_en   = 1'b1;
        wr_idx  = bus_addr[p][WORD_AW-1:0];
        wr_data = bus_wdata[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  logic [LAT-1:0][NPORT-1:0]             done_q;
  logic [LAT-1:0][NPORT-1:0][DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= '0;
      data_q <= '0;
    end else begin
      done_q[0] <= accept;
      for (int p = 0; p < NPORT; p++)
        data_q[0][p] <= rd_hit[p] ? mem[bus_addr[p][WORD_AW-1:0]] : '0;
      for (int s = 1; s < LAT; s++) begin
        done_q[s] <= done_q[s-1];
        data_q[s] <= data_q[s-1];
      end
    end
  end

  assign bus_done  = done_q[LAT-1];
  assign bus_rdata = data_q[LAT-1];

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit[p] |-> ##4 bus_done[p]);
    p_done_has_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_done[p] |-> $past(bus_valid[p], 4));
    p_unselected_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid[p] && !sel[p]) |-> ##4 !bus_done[p]);
    p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_done[p] |-> (bus_rdata[p] == '0));
    if (p > 0) begin : g_lose
      p_loser_no_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req[p] && |(wr_req & NPORT'((1 << p) - 1))) |-> ##4 !bus_done[p]);
    end
  end
endmodule

// File: tb/csm_multiport_tb.sv
module csm_multiport_tb;
  localparam int DW = 32, WAW = 8, SAW = 10, MID = 1, NP = 3;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] bus_valid = '0, bus_we = '0;
  logic [NP-1:0][SAW-1:0] bus_addr = '0;
  logic [NP-1:0][DW-1:0]  bus_wdata = '0;
  logic [NP-1:0][DW-1:0]  bus_rdata;
  logic [NP-1:0]          bus_done;

  always #4 clk = ~clk;

  csm_multiport #(.DATA_W(DW), .WORD_AW(WAW), .SYS_AW(SAW), .MODULE_ID(MID), .NPORT(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done));

  int total = 0, fails = 0, k = 0;
  bit finished = 0;
  string scen = "R1";
  logic [DW-1:0] mm [256];
  bit            exp_d [8][NP];
  logic [DW-1:0] exp_v [8][NP];
  string         tag_s [8];

  function automatic logic [SAW-1:0] mk(input int md, input int idx);
    return {2'(md), 8'(idx)};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: writes are applied after this clock's reads
  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0;
      for (int s = 0; s < 8; s++) for (int p = 0; p < NP; p++) begin exp_d[s][p] = 0; exp_v[s][p] = '0; end
    end else begin
      int slot, win;
      k++;
      slot = (k + 3) % 8;
      tag_s[slot] = scen;
      win = -1;
      for (int p = 0; p < NP; p++) begin
        exp_d[slot][p] = 0; exp_v[slot][p] = '0;
        if (bus_valid[p] && int'(bus_addr[p][SAW-1:WAW]) == MID) begin
          if (!bus_we[p]) begin exp_d[slot][p] = 1; exp_v[slot][p] = mm[bus_addr[p][WAW-1:0]]; end
          else if (win < 0) begin win = p; exp_d[slot][p] = 1; end
        end
      end
      if (win >= 0) mm[bus_addr[win][WAW-1:0]] = bus_wdata[win];
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) check("R1 done in reset", 32'(bus_done[p]), 32'd0);
    end else if (!finished) begin
      int s;
      s = k % 8;
      for (int p = 0; p < NP; p++) begin
        check({tag_s[s], " done"}, 32'(bus_done[p]), 32'(exp_d[s][p]));
        check({tag_s[s], " rdata"}, bus_rdata[p], exp_v[s][p]);
      end
    end
  end

  task automatic idle_all();
    bus_valid = '0; bus_we = '0;
  endtask

  task automatic put(input int p, input bit we, input logic [SAW-1:0] a, input logic [DW-1:0] d);
    bus_valid[p] = 1; bus_we[p] = we; bus_addr[p] = a; bus_wdata[p] = d;
  endtask

  task automatic step();
    @(negedge clk);
    idle_all();
  endtask

  task automatic drain();
    scen = "R8";
    repeat (6) step();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: nothing completes right after reset
    scen = "R1";
    repeat (4) step();
    // fill the store (R4 writes, rdata stays zero)
    scen = "R4";
    for (int i = 0; i < 256; i++) begin put(0, 1, mk(MID, i), 32'hA500_0000 + 32'(i * 7)); step(); end
    drain();
    // R2: single reads with gaps
    scen = "R2";
    for (int i = 0; i < 6; i++) begin put(1, 0, mk(MID, i * 41), '0); step(); step(); end
    drain();
    // R3: three readers same word, then different words
    scen = "R3";
    for (int p = 0; p < NP; p++) put(p, 0, mk(MID, 17), '0);
    step();
    for (int p = 0; p < NP; p++) put(p, 0, mk(MID, 200 + p), '0);
    step();
    drain();
    // R4: write on port 2 then read back on port 0
    scen = "R4";
    put(2, 1, mk(MID, 90), 32'hDEAD_BEEF); step();
    put(0, 0, mk(MID, 90), '0); step();
    drain();
    // R5: three writers collide, only port 0 lands; then retries
    scen = "R5";
    for (int p = 0; p < NP; p++) put(p, 1, mk(MID, 120 + p), 32'h5000 + 32'(p));
    step();
    for (int p = 0; p < NP; p++) put(p, 0, mk(MID, 120 + p), '0);
    step();
    put(1, 1, mk(MID, 121), 32'h5001); put(2, 1, mk(MID, 122), 32'h5002); step();
    put(2, 1, mk(MID, 122), 32'h5002); step();
    for (int p = 0; p < NP; p++) put(p, 0, mk(MID, 120 + p), '0);
    step();
    drain();
    // R6: read meets write to same word, then a later read
    scen = "R6";
    put(0, 1, mk(MID, 33), 32'h0BAD_F00D); put(1, 0, mk(MID, 33), '0); step();
    put(2, 0, mk(MID, 33), '0); step();
    drain();
    // R7: other module numbers ignored, content untouched
    scen = "R7";
    put(0, 1, mk(MID + 1, 44), 32'h1111_1111); put(1, 0, mk(0, 44), '0); put(2, 1, mk(3, 45), 32'h2222); step();
    put(0, 0, mk(MID, 44), '0); put(1, 0, mk(MID, 45), '0); step();
    drain();
    // R9: back-to-back random mixed traffic on all ports
    scen = "R9";
    for (int c = 0; c < 600; c++) begin
      for (int p = 0; p < NP; p++) begin
        if ($urandom % 4 != 0)
          put(p, ($urandom % 3) == 0, mk(($urandom % 6 == 0) ? 2 : MID, $urandom % 16), $urandom);
      end
      step();
    end
    drain();
    finish_run();
  end
endmodule